// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block is the receive half of an asynchronous serial port. It watches a serial input line, sampled on a 16x oversampling tick supplied from outside, and rebuilds each character from a start bit, seven or eight data bits sent least significant bit first, an optional parity bit, and one or two stop bits. When a character is complete, the block copies it from its shift register into a receive buffer. In that same step it updates three error flags (overrun, framing, parity), an error-summary flag and a one-cycle receive interrupt request.

Software-style controls sit beside the line input. A receive enable and a three-bit mode field together turn the receiver on; mode code 000 means the port is invalid. Further controls set parity on or off, odd or even parity, the stop-bit count and the character length. A strobe marks a read of the low byte of the buffer. Each flag has its own clearing rule. An overrun survives buffer reads and is removed only by turning the receiver off. Framing and parity flags are also removed by a buffer read.

Top module: `uart_rx_err_top`

## Requirements
- R1: Data bits arrive least significant bit first. With `len8_i`=1 there are 8 data bits; with `len8_i`=0 there are 7, and bit 7 of `rbuf_o` reads 0. After the last stop bit the word appears on `rbuf_o` and `rx_done_o` becomes 1.
- R2: Each bit lasts 16 ticks of `baud_tick_i`, counted from the first tick that sees the line low. A bit's value is the majority of the samples at ticks 7, 8 and 9 of that bit. If that majority is 1 for the start bit, the start is discarded and no word is loaded.
- R3: With `par_en_i`=1 a parity bit follows the data. `par_odd_i`=0 expects an even count of ones across the data bits and the parity bit; `par_odd_i`=1 expects an odd count. A mismatch sets `par_err_o` when the word is loaded.
- R4: The stop-bit count is 1 when `two_stop_i`=0 and 2 when `two_stop_i`=1. If any expected stop bit is sampled as 0, `frm_err_o` is set when the word is loaded.
- R5: A word loaded while `rx_done_o`=1, with no read strobe in that cycle, sets `ovr_err_o`. The new word still replaces the buffer contents.
- R6: `rx_irq_o` pulses for one cycle, one cycle after each load. The exception is a load that causes an overrun and has neither a framing nor a parity error; that load raises no pulse.
- R7: A `rd_lo_i` pulse clears `rx_done_o`, `frm_err_o` and `par_err_o`. It leaves `ovr_err_o` unchanged.
- R8: While `rx_en_i`=0 or `mode_sel_i`=000, the receiver is held idle, incoming characters are ignored, and `rx_done_o` and all error flags are cleared.
- R9: `err_sum_o` is 1 while any of the three error flags is 1. It returns to 0 only once all three are clear.
- R10: When `rd_lo_i` and a load fall in the same cycle, the load wins: `rx_done_o` stays 1, no overrun is flagged, and the framing and parity flags show the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick_i | input | 1 | One pulse per oversampling period (16 per bit) |
| rx_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receive enable |
| mode_sel_i | input | 3 | Port mode; 000 means invalid and disables the receiver |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop_i | input | 1 | 1 = two stop bits, 0 = one |
| len8_i | input | 1 | 1 = 8 data bits, 0 = 7 |
| rd_lo_i | input | 1 | Strobe marking a read of the buffer low byte |
| rbuf_o | output | 8 | Receive buffer |
| rx_done_o | output | 1 | Receive-complete flag |
| ovr_err_o | output | 1 | Overrun error flag |
| frm_err_o | output | 1 | Framing error flag |
| par_err_o | output | 1 | Parity error flag |
| err_sum_o | output | 1 | Error summary flag |
| rx_irq_o | output | 1 | Receive interrupt request pulse |

## Verification
The assertions check the flag rules on every cycle:
- an overrun holds while the receiver stays on;
- a read clears the receive-complete, framing and parity flags;
- disabling the receiver clears everything;
- the interrupt follows or is withheld according to the error mix of the word just loaded;
- the summary flag falls only once all three flags are clear;
- a load that collides with a read keeps the complete flag set.

Other behaviours depend on what arrives on the line, and only the bench scenarios can show them: bit order, the 7-bit masking, the parity arithmetic in both senses, a bad first or second stop bit, glitch rejection, and a buffer overwritten on overrun. The bench covers them by sweeping every character format over several data words.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int          RX_DW    = 8;
    localparam logic [2:0]  MODE_OFF = 3'b000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic len8;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } rx_cfg_t;

    typedef struct packed {
        logic [RX_DW-1:0] data;
        logic             frm_err;
        logic             par_err;
    } rx_frame_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic parity_bad(input logic [RX_DW-1:0] d, input logic p,
                                        input logic odd);
        return ((^d) ^ p) != odd;
    endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int OVS  = 16,
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic rx_i,
    input  logic hunt_i,
    output logic start_o,
    output logic mid_o,
    output logic end_o,
    output logic bit_o
);
    localparam int            PW     = $clog2(OVS);
    localparam logic [PW-1:0] PH_LO  = PW'(OVS / 2 - 1);
    localparam logic [PW-1:0] PH_MID = PW'(OVS / 2);
    localparam logic [PW-1:0] PH_HI  = PW'(OVS / 2 + 1);
    localparam logic [PW-1:0] PH_END = PW'(OVS - 1);

    logic [SYNC-1:0] sync_q;
    logic [PW-1:0]   phase_q;
    logic            s_lo_q;
    logic            s_mid_q;
    logic            rx_s;
    logic            run_tick;

    assign rx_s     = sync_q[SYNC-1];
    assign run_tick = tick_i & ~hunt_i;
    assign start_o  = tick_i & hunt_i & ~rx_s;
    assign mid_o    = run_tick & (phase_q == PH_HI);
    assign end_o    = run_tick & (phase_q == PH_END);
    assign bit_o    = maj3(s_lo_q, s_mid_q, rx_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            phase_q <= '0;
            s_lo_q  <= 1'b1;
            s_mid_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], rx_i};
            if (start_o) begin
                phase_q <= PW'(1);
            end else if (run_tick) begin
                phase_q <= phase_q + PW'(1);
                if (phase_q == PH_LO)  s_lo_q  <= rx_s;
                if (phase_q == PH_MID) s_mid_q <= rx_s;
            end
        end
    end

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_i,
    input  logic      rx_i,
    input  logic      active_i,
    input  rx_cfg_t   cfg_i,
    output logic      frame_vld_o,
    output rx_frame_t frame_o
);
    localparam int IW = $clog2(RX_DW);

    rx_state_e        state_q;
    logic [IW-1:0]    idx_q;
    logic [IW-1:0]    last_idx;
    logic [RX_DW-1:0] shreg_q;
    logic             pbit_q;
    logic             stop_bad_q;
    logic             start_s, mid_s, end_s, bit_s;
    logic             hunt;

    assign hunt     = (state_q == ST_IDLE);
    assign last_idx = cfg_i.len8 ? IW'(RX_DW - 1) : IW'(RX_DW - 2);

    uart_rx_sampler #(.OVS(OVS), .SYNC(2)) u_smp (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .rx_i    (rx_i),
        .hunt_i  (hunt),
        .start_o (start_s),
        .mid_o   (mid_s),
        .end_o   (end_s),
        .bit_o   (bit_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            idx_q       <= '0;
            shreg_q     <= '0;
            pbit_q      <= 1'b0;
            stop_bad_q  <= 1'b0;
            frame_vld_o <= 1'b0;
            frame_o     <= '0;
        end else begin
            frame_vld_o <= 1'b0;
            if (!active_i) begin
                state_q <= ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_IDLE: if (start_s) begin
                        state_q    <= ST_START;
                        shreg_q    <= '0;
                        pbit_q     <= 1'b0;
                        stop_bad_q <= 1'b0;
                        idx_q      <= '0;
                    end
                    ST_START: begin
                        if (mid_s && bit_s) state_q <= ST_IDLE;
                        else if (end_s)     state_q <= ST_DATA;
                    end
                    ST_DATA: begin
                        if (mid_s) shreg_q[idx_q] <= bit_s;
                        if (end_s) begin
                            if (idx_q == last_idx)
                                state_q <= cfg_i.par_en ? ST_PAR : ST_STOP1;
                            else
                                idx_q <= idx_q + IW'(1);
                        end
                    end
                    ST_PAR: begin
                        if (mid_s) pbit_q  <= bit_s;
                        if (end_s) state_q <= ST_STOP1;
                    end
                    ST_STOP1: begin
                        if (mid_s) begin
                            if (cfg_i.two_stop) begin
                                stop_bad_q <= ~bit_s;
                            end else begin
                                frame_vld_o     <= 1'b1;
                                frame_o.data    <= shreg_q;
                                frame_o.frm_err <= ~bit_s;
                                frame_o.par_err <= cfg_i.par_en &
                                    parity_bad(shreg_q, pbit_q, cfg_i.par_odd);
                                state_q         <= ST_IDLE;
                            end
                        end else if (end_s) begin
                            state_q <= ST_STOP2;
                        end
                    end
                    ST_STOP2: if (mid_s) begin
                        frame_vld_o     <= 1'b1;
                        frame_o.data    <= shreg_q;
                        frame_o.frm_err <= stop_bad_q | ~bit_s;
                        frame_o.par_err <= cfg_i.par_en &
                            parity_bad(shreg_q, pbit_q, cfg_i.par_odd);
                        state_q         <= ST_IDLE;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active_i,
    input  logic             rd_i,
    input  logic             frame_vld_i,
    input  rx_frame_t        frame_i,
    output logic [RX_DW-1:0] rbuf_o,
    output logic             done_o,
    output logic             ovr_o,
    output logic             frm_o,
    output logic             par_o,
    output logic             sum_o,
    output logic             irq_o
);
    logic ovr_hit;
    logic ovr_d, frm_d, par_d;

    always_comb begin
        ovr_hit = frame_vld_i & done_o & ~rd_i;
        ovr_d   = ovr_o | ovr_hit;
        frm_d   = (frm_o & ~rd_i) | (frame_vld_i & frame_i.frm_err);
        par_d   = (par_o & ~rd_i) | (frame_vld_i & frame_i.par_err);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbuf_o <= '0;
            done_o <= 1'b0;
            ovr_o  <= 1'b0;
            frm_o  <= 1'b0;
            par_o  <= 1'b0;
            sum_o  <= 1'b0;
            irq_o  <= 1'b0;
        end else if (!active_i) begin
            done_o <= 1'b0;
            ovr_o  <= 1'b0;
            frm_o  <= 1'b0;
            par_o  <= 1'b0;
            sum_o  <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            if (frame_vld_i) rbuf_o <= frame_i.data;
            done_o <= frame_vld_i | (done_o & ~rd_i);
            ovr_o  <= ovr_d;
            frm_o  <= frm_d;
            par_o  <= par_d;
            sum_o  <= ovr_d | frm_d | par_d;
            irq_o  <= frame_vld_i & (~ovr_hit | frame_i.frm_err | frame_i.par_err);
        end
    end

endmodule

// File: rtl/uart_rx_err_top.sv
module uart_rx_err_top
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick_i,
    input  logic       rx_i,
    input  logic       rx_en_i,
    input  logic [2:0] mode_sel_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    input  logic       two_stop_i,
    input  logic       len8_i,
    input  logic       rd_lo_i,
    output logic [7:0] rbuf_o,
    output logic       rx_done_o,
    output logic       ovr_err_o,
    output logic       frm_err_o,
    output logic       par_err_o,
    output logic       err_sum_o,
    output logic       rx_irq_o
);
    logic      active;
    rx_cfg_t   cfg;
    logic      frame_vld;
    rx_frame_t frame;

    assign active       = rx_en_i & (mode_sel_i != MODE_OFF);
    assign cfg.len8     = len8_i;
    assign cfg.par_en   = par_en_i;
    assign cfg.par_odd  = par_odd_i;
    assign cfg.two_stop = two_stop_i;

    uart_rx_framer #(.OVS(OVS)) u_frm (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (baud_tick_i),
        .rx_i        (rx_i),
        .active_i    (active),
        .cfg_i       (cfg),
        .frame_vld_o (frame_vld),
        .frame_o     (frame)
    );

    uart_rx_status u_sts (
        .clk         (clk),
        .rst         (rst),
        .active_i    (active),
        .rd_i        (rd_lo_i),
        .frame_vld_i (frame_vld),
        .frame_i     (frame),
        .rbuf_o      (rbuf_o),
        .done_o      (rx_done_o),
        .ovr_o       (ovr_err_o),
        .frm_o       (frm_err_o),
        .par_o       (par_err_o),
        .sum_o       (err_sum_o),
        .irq_o       (rx_irq_o)
    );

endmodule

// File: rtl/uart_rx_err_chk.sv
module uart_rx_err_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_en_i,
    input logic [2:0] mode_sel_i,
    input logic       rd_lo_i,
    input logic       frame_vld,
    input logic       f_frm,
    input logic       f_par,
    input logic       rx_done_o,
    input logic       ovr_err_o,
    input logic       frm_err_o,
    input logic       par_err_o,
    input logic       err_sum_o,
    input logic       rx_irq_o
);
    logic on;
    assign on = rx_en_i && (mode_sel_i != 3'b000);

    a_r1_done_from_load: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_done_o) |-> $past(frame_vld));

    a_r5_ovr_sets: assert property (@(posedge clk) disable iff (rst)
        (on && frame_vld && rx_done_o && !rd_lo_i) |=> (ovr_err_o && rx_done_o));

    a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (on && ovr_err_o) |=> ovr_err_o);

    a_r6_ovr_no_irq: assert property (@(posedge clk) disable iff (rst)
        (on && frame_vld && rx_done_o && !rd_lo_i && !f_frm && !f_par) |=> !rx_irq_o);

    a_r6_err_irq: assert property (@(posedge clk) disable iff (rst)
        (on && frame_vld && (f_frm || f_par)) |=> rx_irq_o);

    a_r6_irq_cause: assert property (@(posedge clk) disable iff (rst)
        rx_irq_o |-> $past(frame_vld));

    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        (on && rd_lo_i && !frame_vld) |=> (!rx_done_o && !frm_err_o && !par_err_o));

    a_r8_off_clears: assert property (@(posedge clk) disable iff (rst)
        !on |=> (!rx_done_o && !ovr_err_o && !frm_err_o && !par_err_o &&
                 !err_sum_o && !rx_irq_o));

    a_r9_sum_falls_clean: assert property (@(posedge clk) disable iff (rst)
        $fell(err_sum_o) |-> (!ovr_err_o && !frm_err_o && !par_err_o));

    a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
        (on && frame_vld && rd_lo_i) |=> (rx_done_o && !$rose(ovr_err_o)));

endmodule

bind uart_rx_err_top uart_rx_err_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_en_i    (rx_en_i),
    .mode_sel_i (mode_sel_i),
    .rd_lo_i    (rd_lo_i),
    .frame_vld  (frame_vld),
    .f_frm      (frame.frm_err),
    .f_par      (frame.par_err),
    .rx_done_o  (rx_done_o),
    .ovr_err_o  (ovr_err_o),
    .frm_err_o  (frm_err_o),
    .par_err_o  (par_err_o),
    .err_sum_o  (err_sum_o),
    .rx_irq_o   (rx_irq_o)
);

// File: tb/uart_rx_err_top_tb.sv
module uart_rx_err_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rx = 1'b1;
    logic       rx_en = 1'b0;
    logic [2:0] mode = 3'b001;
    logic       pe = 1'b0, po = 1'b0, two = 1'b0, l8 = 1'b1;
    logic       rd = 1'b0;
    logic [7:0] rbuf;
    logic       done, ovr, frm, par, esum, irq;

    int n_chk = 0;
    int n_fail = 0;
    int irq_cnt = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    always @(negedge clk) tick <= rst ? 1'b0 : ~tick;
    always @(posedge clk) if (!rst && irq) irq_cnt <= irq_cnt + 1;

    uart_rx_err_top dut_i (
        .clk (clk), .rst (rst), .baud_tick_i (tick), .rx_i (rx),
        .rx_en_i (rx_en), .mode_sel_i (mode), .par_en_i (pe), .par_odd_i (po),
        .two_stop_i (two), .len8_i (l8), .rd_lo_i (rd),
        .rbuf_o (rbuf), .rx_done_o (done), .ovr_err_o (ovr), .frm_err_o (frm),
        .par_err_o (par), .err_sum_o (esum), .rx_irq_o (irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic hold(input logic b, input int ticks);
        rx = b;
        repeat (ticks * 2) @(negedge clk);
    endtask

    // bad_stop: 0 none, 1 first stop low, 2 second stop low
    task automatic send(input logic [7:0] d, input logic bad_par, input int bad_stop);
        int nb;
        logic [7:0] m;
        nb = l8 ? 8 : 7;
        m  = l8 ? d : (d & 8'h7F);
        hold(1'b0, 16);
        for (int i = 0; i < nb; i++) hold(d[i], 16);
        if (pe) hold((^m) ^ po ^ bad_par, 16);
        for (int s = 1; s <= (two ? 2 : 1); s++) begin
            if (bad_stop == s) begin
                hold(1'b0, 12);
                hold(1'b1, 4);
            end else begin
                hold(1'b1, 16);
            end
        end
        hold(1'b1, 24);
    endtask

    task automatic read_lo();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic frame_check(input logic [7:0] d, input logic bad_par, input int bad_stop);
        int i0;
        logic [7:0] m;
        logic ef, ep;
        m  = l8 ? d : (d & 8'h7F);
        ef = (bad_stop != 0);
        ep = pe & bad_par;
        i0 = irq_cnt;
        send(d, bad_par, bad_stop);
        chk("R1", "rbuf", {24'd0, rbuf}, {24'd0, m});
        chk("R1", "done", done, 1);
        chk("R4", "frm", frm, ef);
        chk("R3", "par", par, ep);
        chk("R6", "irq pulses", irq_cnt - i0, 1);
        chk("R9", "sum", esum, ef | ep);
        read_lo();
        chk("R7", "done after read", done, 0);
        chk("R7", "frm/par after read", {frm, par}, 0);
        chk("R9", "sum after read", esum, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        int i0;
        logic [7:0] prev;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R8", "reset flags", {done, ovr, frm, par, esum, irq}, 0);
        chk("R1", "reset rbuf", {24'd0, rbuf}, 0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // R1 R3 R4: sweep all character formats with clean words
        for (int c = 0; c < 12; c++) begin
            l8  = c[0];
            two = c[1];
            pe  = (c / 4) != 0;
            po  = (c / 4) == 2;
            for (int k = 0; k < 8; k++) begin
                logic [7:0] d;
                d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(k * 73 + c * 29 + 5);
                frame_check(d, 1'b0, 0);
            end
        end

        // R3: parity errors in both senses
        l8 = 1; two = 0; pe = 1; po = 0; frame_check(8'h5A, 1'b1, 0);
        l8 = 0; two = 1; pe = 1; po = 1; frame_check(8'hC3, 1'b1, 0);
        l8 = 1; two = 0; pe = 1; po = 1; frame_check(8'h01, 1'b1, 0);

        // R4: framing errors on first and second stop bit
        l8 = 1; two = 0; pe = 0; po = 0; frame_check(8'h3C, 1'b0, 1);
        l8 = 1; two = 1; pe = 1; po = 1; frame_check(8'h96, 1'b0, 2);
        l8 = 0; two = 1; pe = 0; po = 0; frame_check(8'h7E, 1'b0, 1);
        l8 = 1; two = 0; pe = 1; po = 0; frame_check(8'hA5, 1'b1, 1);

        // R2: short low glitch is rejected, receiver still works afterwards
        l8 = 1; two = 0; pe = 0;
        i0 = irq_cnt;
        prev = rbuf;
        hold(1'b0, 4);
        hold(1'b1, 40);
        chk("R2", "glitch done", done, 0);
        chk("R2", "glitch irq", irq_cnt - i0, 0);
        chk("R2", "glitch rbuf", {24'd0, rbuf}, {24'd0, prev});
        frame_check(8'h81, 1'b0, 0);

        // R5 R6 R7 R8: overrun
        send(8'h11, 1'b0, 0);
        i0 = irq_cnt;
        send(8'h22, 1'b0, 0);
        chk("R5", "rbuf overwritten", {24'd0, rbuf}, 32'h22);
        chk("R5", "ovr set", ovr, 1);
        chk("R6", "no irq on overrun", irq_cnt - i0, 0);
        chk("R9", "sum on ovr", esum, 1);
        read_lo();
        chk("R7", "done cleared", done, 0);
        chk("R7", "ovr kept after read", ovr, 1);
        chk("R9", "sum kept", esum, 1);
        rx_en = 1'b0;
        @(negedge clk);
        chk("R8", "disable clears ovr", {ovr, esum}, 0);
        rx_en = 1'b1;
        @(negedge clk);

        // R6: overrun combined with parity error still interrupts
        pe = 1; po = 0;
        send(8'h33, 1'b0, 0);
        i0 = irq_cnt;
        send(8'h44, 1'b1, 0);
        chk("R6", "irq on ovr+parity", irq_cnt - i0, 1);
        chk("R5", "ovr with parity", {ovr, par}, 2'b11);
        read_lo();
        chk("R7", "parity cleared, ovr kept", {ovr, par}, 2'b10);
        rx_en = 1'b0;
        @(negedge clk);
        rx_en = 1'b1;
        pe = 0;

        // R8: mode 000 clears framing flag
        send(8'h55, 1'b0, 1);
        chk("R4", "frm before mode off", frm, 1);
        mode = 3'b000;
        @(negedge clk);
        chk("R8", "mode off clears", {done, frm, esum}, 0);
        mode = 3'b001;
        @(negedge clk);

        // R8: frames ignored while disabled
        rx_en = 1'b0;
        i0 = irq_cnt;
        prev = rbuf;
        send(8'hE7, 1'b0, 0);
        chk("R8", "ignored done", done, 0);
        chk("R8", "ignored irq", irq_cnt - i0, 0);
        chk("R8", "ignored rbuf", {24'd0, rbuf}, {24'd0, prev});
        rx_en = 1'b1;
        @(negedge clk);

        // R10: read strobe coincides with the load
        prev = rbuf;
        fork
            send(8'h6D, 1'b0, 0);
            begin
                rd = 1'b1;
                while (rbuf === prev) @(negedge clk);
                rd = 1'b0;
                chk("R10", "done kept on collision", done, 1);
                chk("R10", "no overrun on collision", ovr, 0);
            end
        join
        chk("R10", "rbuf after collision", {24'd0, rbuf}, 32'h6D);
        chk("R10", "done still set", done, 1);

        finished = 1;
        report();
    end

endmodule